// File: doc/BRIEF.md
# Host Controller Interrupt Aggregator

This block merges six event sources of a host controller core into a single level-sensitive interrupt line. Each source has one status bit and one enable bit, and both sit at the same bit position in two 32-bit registers. A one-cycle pulse from the core sets a status bit, whatever the state of its enable. Software reaches the two registers through a plain word-wide port. A select line chooses the register, a write strobe stores data, and the read data follows the select with no added cycle.

The sources come in two classes. Port change, frame list rollover and host system error are immediate: an enabled, set status bit drives the line at once. Transfer completion, transfer error and async-advance are deferred. An enabled, set status bit of this class waits for the next pulse on the threshold tick input. At that tick it is latched into a pending flag, and the flag keeps the line high until software clears the status bit. Software acknowledges a source by writing 1 to its status bit.

Top module: `hc_irq_agg`

## Requirements
- R1: While rst is high, and in the cycle after it, the enable register reads 0, the status register reads 0 and irq is 0.
- R2: With reg_sel=0, a write stores reg_wdata[5:0] in the enable register. A read with reg_sel=0 returns the enable bits in [5:0] and 0 in [31:6]. Writes to bits 31:6 have no effect.
- R3: A pulse on evt_pulse[i] sets status bit i at the next clock edge, even when enable bit i is 0. Status is read with reg_sel=1, with 0 in bits [31:6]. The bit assignment is: 0 transfer done, 1 transfer error, 2 port change, 3 frame list rollover, 4 host system error, 5 async advance.
- R4: With reg_sel=1, a write clears every status bit whose reg_wdata bit is 1 and leaves the bits written with 0 unchanged. An event pulse in the same cycle as a clear of its bit leaves the bit set.
- R5: For the immediate bits 2, 3 and 4, irq is high in the cycle after the clock edge at which both the status bit and the enable bit become 1.
- R6: For the deferred bits 0, 1 and 5, a set, enabled status bit raises irq only after a thresh_tick pulse that is sampled while the bit is already set and enabled. A tick that arrives in the same cycle as the event does not latch it.
- R7: Once latched, a deferred source holds irq high until its status bit is cleared, even if its enable bit is cleared first. A tick while the enable bit is 0 latches nothing.
- R8: Writing the enable register never clears a status bit. Clearing the enable bit of an immediate source drops that source's contribution to irq.
- R9: irq goes low in the cycle after the write that clears the last contributing status bit.
- R10: A status bit whose enable bit is 0, and which was not latched while enabled, does not raise irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register select: 0 enable, 1 status |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register, combinational |
| evt_pulse | input | 6 | One-cycle event pulses, one per source |
| thresh_tick | input | 1 | One-cycle interrupt-threshold boundary pulse |
| irq | output | 1 | Level-sensitive interrupt output |

## Verification
The bench targets these corner cases:
- A tick in the same cycle as a deferred event. A design that samples the incoming event instead of the stored bit would raise irq one threshold period early.
- An enable cleared after a deferred source has latched. A design that gates the pending flag with the enable would drop the line before software acknowledges it.
- A clear that collides with a fresh event on the same bit. A design where the clear wins would lose the event.
- Writes of 0 and of all ones to reserved bits. These expose a status bit cleared by a 0, or reserved bits that read back non-zero.

// File: rtl/hc_irq_pkg.sv
package hc_irq_pkg;

    localparam int SRC_N  = 6;
    localparam int WORD_W = 32;

    typedef logic [SRC_N-1:0] src_vec_t;

    typedef enum int {
        SRC_XFER   = 0,
        SRC_XERR   = 1,
        SRC_PORT   = 2,
        SRC_ROLL   = 3,
        SRC_SYSERR = 4,
        SRC_ASYNC  = 5
    } src_e;

    // Sources that wait for a threshold boundary
    localparam src_vec_t DEFER_MASK =
        src_vec_t'((1 << SRC_XFER) | (1 << SRC_XERR) | (1 << SRC_ASYNC));
    localparam src_vec_t IMM_MASK = ~DEFER_MASK;

    typedef enum logic {
        SEL_ENABLE = 1'b0,
        SEL_STATUS = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic     wr_en;
        logic     wr_stat;
        src_vec_t data;
    } reg_wr_t;

    function automatic logic [WORD_W-1:0] widen(src_vec_t v);
        return {{(WORD_W-SRC_N){1'b0}}, v};
    endfunction

endpackage

// File: rtl/hc_irq_regfile.sv
module hc_irq_regfile
    import hc_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  reg_wr_t  wr,
    input  src_vec_t evt,
    output src_vec_t en_q,
    output src_vec_t stat_q,
    output src_vec_t clr
);

    assign clr = wr.wr_stat ? wr.data : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (wr.wr_en) begin
            en_q <= wr.data;
        end
    end

    // Event set has priority over a write-one clear
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr) | evt;
        end
    end

endmodule

// File: rtl/hc_irq_defer.sv
module hc_irq_defer
    import hc_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  src_vec_t en_q,
    input  src_vec_t stat_q,
    input  src_vec_t clr,
    output src_vec_t pend_q
);

    for (genvar i = 0; i < SRC_N; i++) begin : g_pend
        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q[i] <= 1'b0;
            end else begin
                pend_q[i] <= DEFER_MASK[i] & stat_q[i] & ~clr[i]
                           & (pend_q[i] | (tick & en_q[i]));
            end
        end
    end

endmodule

// File: rtl/hc_irq_merge.sv
module hc_irq_merge
    import hc_irq_pkg::*;
(
    input  src_vec_t en_q,
    input  src_vec_t stat_q,
    input  src_vec_t pend_q,
    output logic     irq
);

    src_vec_t imm_hit;
    src_vec_t def_hit;

    always_comb begin
        imm_hit = stat_q & en_q & IMM_MASK;
        def_hit = stat_q & pend_q;
        irq     = |(imm_hit | def_hit);
    end

endmodule

// File: rtl/hc_irq_agg.sv
module hc_irq_agg
    import hc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_sel,
    input  logic              reg_we,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic [SRC_N-1:0]  evt_pulse,
    input  logic              thresh_tick,
    output logic              irq
);

    reg_wr_t  wr;
    src_vec_t en_q;
    src_vec_t stat_q;
    src_vec_t pend_q;
    src_vec_t clr;
    logic     rsvd_unused;

    assign rsvd_unused = ^reg_wdata[WORD_W-1:SRC_N];

    always_comb begin
        wr.wr_en   = reg_we && (reg_sel_e'(reg_sel) == SEL_ENABLE);
        wr.wr_stat = reg_we && (reg_sel_e'(reg_sel) == SEL_STATUS);
        wr.data    = reg_wdata[SRC_N-1:0];
    end

    hc_irq_regfile u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr),
        .evt    (evt_pulse),
        .en_q   (en_q),
        .stat_q (stat_q),
        .clr    (clr)
    );

    hc_irq_defer u_defer (
        .clk    (clk),
        .rst    (rst),
        .tick   (thresh_tick),
        .en_q   (en_q),
        .stat_q (stat_q),
        .clr    (clr),
        .pend_q (pend_q)
    );

    hc_irq_merge u_merge (
        .en_q   (en_q),
        .stat_q (stat_q),
        .pend_q (pend_q),
        .irq    (irq)
    );

    assign reg_rdata = widen((reg_sel_e'(reg_sel) == SEL_STATUS) ? stat_q : en_q);

endmodule

// File: rtl/hc_irq_chk.sv
module hc_irq_chk
    import hc_irq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_sel,
    input logic              reg_we,
    input logic [SRC_N-1:0]  wdata,
    input logic [WORD_W-1:0] reg_rdata,
    input logic [SRC_N-1:0]  evt,
    input logic              tick,
    input logic              irq,
    input src_vec_t          en_q,
    input src_vec_t          stat_q,
    input src_vec_t          pend_q
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (stat_q == '0 && en_q == '0 && !irq));  // R1

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[WORD_W-1:SRC_N] == '0);  // R2

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((stat_q & $past(evt)) == $past(evt)));  // R3

    AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_sel) |=>
        ((stat_q & ($past(stat_q) & ~$past(wdata))) == ($past(stat_q) & ~$past(wdata))));  // R4

    AST_DEFER_WAITS: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (((stat_q & en_q & IMM_MASK) != '0) || $past(tick)));  // R6

    AST_PEND_NEEDS_STAT: assert property (@(posedge clk) disable iff (rst)
        (pend_q & ~stat_q) == '0);  // R7

    AST_EN_KEEPS_STAT: assert property (@(posedge clk) disable iff (rst)
        (reg_we && !reg_sel) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));  // R8

    AST_NO_STAT_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
        (stat_q == '0) |-> !irq);  // R9

endmodule

bind hc_irq_agg hc_irq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_sel   (reg_sel),
    .reg_we    (reg_we),
    .wdata     (reg_wdata[SRC_N-1:0]),
    .reg_rdata (reg_rdata),
    .evt       (evt_pulse),
    .tick      (thresh_tick),
    .irq       (irq),
    .en_q      (en_q),
    .stat_q    (stat_q),
    .pend_q    (pend_q)
);

// File: tb/test_hc_irq_agg.sv
module test_hc_irq_agg;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_sel = 1'b0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [5:0]  evt_pulse = '0;
    logic        thresh_tick = 1'b0;
    logic        irq;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    hc_irq_agg i_hc_irq_agg (
        .clk         (clk),
        .rst         (rst),
        .reg_sel     (reg_sel),
        .reg_we      (reg_we),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .evt_pulse   (evt_pulse),
        .thresh_tick (thresh_tick),
        .irq         (irq)
    );

    typedef struct packed {
        logic [7:0]  tag;
        logic        sel;
        logic        we;
        logic [31:0] wd;
        logic [5:0]  evt;
        logic        tick;
        logic        x_irq;
        logic [5:0]  x_en;
        logic [5:0]  x_st;
    } vec_t;

    localparam int NV = 21;
    // tag, sel, we, wdata, evt, tick, irq, enable, status
    localparam vec_t VECS [NV] = '{
        '{8'd2,  1'b0, 1'b1, 32'h0000001C, 6'h00, 1'b0, 1'b0, 6'h1C, 6'h00}, // R2 enable immediates
        '{8'd5,  1'b0, 1'b0, 32'h0,        6'h04, 1'b0, 1'b1, 6'h1C, 6'h04}, // R5 port change
        '{8'd4,  1'b1, 1'b1, 32'h0,        6'h00, 1'b0, 1'b1, 6'h1C, 6'h04}, // R4 zero write keeps
        '{8'd9,  1'b1, 1'b1, 32'h00000004, 6'h00, 1'b0, 1'b0, 6'h1C, 6'h00}, // R9 clear drops irq
        '{8'd10, 1'b0, 1'b0, 32'h0,        6'h01, 1'b0, 1'b0, 6'h1C, 6'h01}, // R3 R10 set while disabled
        '{8'd6,  1'b0, 1'b1, 32'h0000003F, 6'h00, 1'b0, 1'b0, 6'h3F, 6'h01}, // R6 waits for tick
        '{8'd6,  1'b0, 1'b0, 32'h0,        6'h00, 1'b1, 1'b1, 6'h3F, 6'h01}, // R6 tick latches
        '{8'd7,  1'b0, 1'b1, 32'h0,        6'h00, 1'b0, 1'b1, 6'h00, 6'h01}, // R7 R8 latched held
        '{8'd3,  1'b0, 1'b0, 32'h0,        6'h08, 1'b0, 1'b1, 6'h00, 6'h09}, // R3 rollover disabled
        '{8'd9,  1'b1, 1'b1, 32'h00000001, 6'h00, 1'b0, 1'b0, 6'h00, 6'h08}, // R9 last contributor
        '{8'd7,  1'b0, 1'b0, 32'h0,        6'h00, 1'b1, 1'b0, 6'h00, 6'h08}, // R7 tick while disabled
        '{8'd5,  1'b0, 1'b1, 32'h00000008, 6'h00, 1'b0, 1'b1, 6'h08, 6'h08}, // R5 enable after status
        '{8'd4,  1'b1, 1'b1, 32'h00000008, 6'h08, 1'b0, 1'b1, 6'h08, 6'h08}, // R4 event beats clear
        '{8'd4,  1'b1, 1'b1, 32'h00000008, 6'h00, 1'b0, 1'b0, 6'h08, 6'h00}, // R4 clear
        '{8'd2,  1'b0, 1'b1, 32'hFFFFFFFF, 6'h00, 1'b0, 1'b0, 6'h3F, 6'h00}, // R2 reserved ignored
        '{8'd6,  1'b0, 1'b0, 32'h0,        6'h20, 1'b1, 1'b0, 6'h3F, 6'h20}, // R6 same-cycle tick
        '{8'd6,  1'b0, 1'b0, 32'h0,        6'h00, 1'b1, 1'b1, 6'h3F, 6'h20}, // R6 next tick
        '{8'd5,  1'b0, 1'b0, 32'h0,        6'h10, 1'b0, 1'b1, 6'h3F, 6'h30}, // R5 system error
        '{8'd9,  1'b1, 1'b1, 32'hFFFFFFE0, 6'h00, 1'b0, 1'b1, 6'h3F, 6'h10}, // R9 one of two cleared
        '{8'd8,  1'b0, 1'b1, 32'h0,        6'h00, 1'b0, 1'b0, 6'h00, 6'h10}, // R8 enable off
        '{8'd9,  1'b1, 1'b1, 32'h00000010, 6'h00, 1'b0, 1'b0, 6'h00, 6'h00}  // R9 all clear
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic read_back(string req, logic x_irq, logic [5:0] x_en, logic [5:0] x_st);
        reg_we = 1'b0;
        evt_pulse = '0;
        thresh_tick = 1'b0;
        chk({req, " irq"}, {31'b0, irq}, {31'b0, x_irq});
        reg_sel = 1'b1;
        #1;
        chk({req, " status"}, reg_rdata, {26'b0, x_st});
        reg_sel = 1'b0;
        #1;
        chk({req, " enable"}, reg_rdata, {26'b0, x_en});
    endtask

    initial begin
        #(8 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        read_back("R1 in reset", 1'b0, 6'h00, 6'h00);
        rst = 1'b0;
        @(posedge clk);
        #1;
        read_back("R1 after reset", 1'b0, 6'h00, 6'h00);

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            reg_sel     = VECS[k].sel;
            reg_we      = VECS[k].we;
            reg_wdata   = VECS[k].wd;
            evt_pulse   = VECS[k].evt;
            thresh_tick = VECS[k].tick;
            @(posedge clk);
            #1;
            read_back($sformatf("R%0d vec%0d", VECS[k].tag, k),
                      VECS[k].x_irq, VECS[k].x_en, VECS[k].x_st);
        end

        // R1: reset mid-run with state present
        @(negedge clk);
        reg_we = 1'b1;
        reg_sel = 1'b0;
        reg_wdata = 32'h3F;
        evt_pulse = 6'h3F;
        @(posedge clk);
        #1;
        read_back("R1 pre", 1'b1, 6'h3F, 6'h3F);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        read_back("R1 mid-run reset", 1'b0, 6'h00, 6'h00);
        @(negedge clk);
        rst = 1'b0;

        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule